// File: doc/BRIEF.md
# Class-Binned Walsh-Hadamard Leakage Spectrum Engine

This engine turns a stream of leakage measurements (toggle counts or any other unsigned per-trace figure) into a spectral view of how the leakage depends on the bits of an unmasked 4-bit value. Each sample arrives with the value it belongs to, its class. The engine keeps a running sum and a sample count for each of the 16 classes. When told to analyse, it divides every class sum by that class's count to get the mean leakage per class. It then runs a 16-point Walsh-Hadamard transform over those means and streams out the fifteen coefficients with a nonzero index.

A coefficient whose index has a single bit set points at one input bit leaking by itself. Coefficients with multi-bit indices point at interactions between several bits. Each output therefore carries a flag marking single-bit indices. The accumulated sums are kept after an analysis. More traces can be added and the spectrum run again, and a separate clear returns all classes to empty.

Top module: `wh_leak_spectrum`

## Requirements
- R1: After reset, out_valid and busy are 0 and every class is empty.
- R2: While the engine is idle, a sample with in_valid high is added to the sum of class in_class and increments that class's count. The mean used for the class is floor(sum / count).
- R3: A class that received no samples has a mean of zero.
- R4: The coefficient for index u equals floor(S_u / 4), where S_u is the sum over all classes t of the mean of t. The mean is added when the parity of (u AND t) is even and subtracted when it is odd. The floor is an arithmetic right shift by 2 of the two's-complement sum.
- R5: One start pulse in idle produces exactly fifteen coefficients on consecutive cycles with out_valid high, indexed u = 1, 2, ..., 15 in ascending order. Index 0 is never output, and out_valid stays low afterwards until the next start.
- R6: out_single is 1 exactly when out_index has one bit set (u = 1, 2, 4, 8) and 0 for the other indices.
- R7: busy is high from the cycle after an accepted start up to and including the cycle of the last coefficient. While busy is high, in_valid samples, start and clear have no effect.
- R8: Sums and counts are kept across an analysis, so a second start with no new samples gives the same coefficients. A clear while idle empties every class.
- R9: Once a class holds 2^CNT_W - 1 samples (255 by default), further samples for that class are dropped.
- R10: Every coefficient lies within plus or minus floor(16 * (2^SAMPLE_W - 1) / 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Empty all classes (idle only); wins over start in the same cycle |
| start | input | 1 | Begin an analysis of the accumulated classes (idle only) |
| in_valid | input | 1 | A leakage sample is present this cycle |
| in_class | input | N_BITS (4) | Unmasked class value of the sample |
| in_sample | input | SAMPLE_W (8) | Unsigned leakage value |
| busy | output | 1 | Analysis or coefficient output in progress |
| out_valid | output | 1 | A coefficient is present this cycle |
| out_index | output | N_BITS (4) | Spectrum index u of the coefficient, 1 to 15 |
| out_coef | output | N_BITS+SAMPLE_W+1 (13) | Signed coefficient, two's complement |
| out_single | output | 1 | The index has exactly one bit set |

## Verification
Each pattern is chosen to isolate one aspect of the mean-and-transform path. A single populated class with a constant value gives a spectrum of equal magnitudes whose signs follow the index parity, which exposes a wrong butterfly pairing or sign. A lone class with mean 1 yields coefficients of 0 and -1, which separates a floor shift from truncation toward zero. A few populated classes with uneven sample counts check the divider's rounding and show that empty classes contribute zero. A pseudo-random fill of all classes exercises every butterfly at once. A saturation run overfills one class, a clear run checks that everything is emptied, and a run that pokes start and samples during emission checks that both are ignored and that a rerun reproduces the previous spectrum.

// File: rtl/wh_pkg.sv
package wh_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DIV_ISSUE,
        PH_DIV_WAIT,
        PH_XFORM,
        PH_EMIT
    } wh_phase_e;

endpackage

// File: rtl/wh_class_accum.sv
module wh_class_accum #(
    parameter int N_BITS   = 4,
    parameter int SAMPLE_W = 8,
    parameter int CNT_W    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [N_BITS-1:0]          wr_class,
    input  logic [SAMPLE_W-1:0]        wr_sample,
    input  logic [N_BITS-1:0]          rd_class,
    output logic [SAMPLE_W+CNT_W-1:0]  rd_sum,
    output logic [CNT_W-1:0]           rd_count
);
    localparam int NCLS  = 1 << N_BITS;
    localparam int SUM_W = SAMPLE_W + CNT_W;

    typedef struct packed {
        logic [NCLS-1:0][SUM_W-1:0] sum;
        logic [NCLS-1:0][CNT_W-1:0] cnt;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (wr_en && (acc_q.cnt[wr_class] != {CNT_W{1'b1}})) begin
            acc_d.sum[wr_class] = acc_q.sum[wr_class] + SUM_W'(wr_sample);
            acc_d.cnt[wr_class] = acc_q.cnt[wr_class] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign rd_sum   = acc_q.sum[rd_class];
    assign rd_count = acc_q.cnt[rd_class];

endmodule

// File: rtl/wh_seq_div.sv
module wh_seq_div #(
    parameter int NUM_W = 16,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CW = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CW-1:0]    cnt;
        logic [DEN_W-1:0] den;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } div_t;

    div_t dv_d, dv_q;
    logic [DEN_W:0] rem_sh;
    logic [DEN_W:0] rem_sub;
    logic           fits;

    always_comb begin
        dv_d    = dv_q;
        dv_d.done = 1'b0;
        rem_sh  = {dv_q.rem, dv_q.quo[NUM_W-1]};
        rem_sub = rem_sh - {1'b0, dv_q.den};
        fits    = (rem_sh >= {1'b0, dv_q.den});
        if (go) begin
            dv_d.busy = 1'b1;
            dv_d.cnt  = CW'(NUM_W);
            dv_d.den  = den;
            dv_d.rem  = '0;
            dv_d.quo  = num;
        end else if (dv_q.busy) begin
            dv_d.rem = fits ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
            dv_d.quo = {dv_q.quo[NUM_W-2:0], fits};
            dv_d.cnt = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done = dv_q.done;
    assign quot = dv_q.quo;

endmodule

// File: rtl/wh_bfly_stage.sv
module wh_bfly_stage #(
    parameter int NCLS   = 16,
    parameter int COEF_W = 13,
    parameter int SPAN   = 1
) (
    input  logic [NCLS-1:0][COEF_W-1:0] vin,
    output logic [NCLS-1:0][COEF_W-1:0] vout
);
    for (genvar i = 0; i < NCLS; i++) begin : g_pt
        if (((i / SPAN) % 2) == 0) begin : g_sum
            assign vout[i] = vin[i] + vin[i+SPAN];
        end else begin : g_dif
            assign vout[i] = vin[i-SPAN] - vin[i];
        end
    end

endmodule

// File: rtl/wh_leak_spectrum.sv
module wh_leak_spectrum #(
    parameter int N_BITS   = 4,
    parameter int SAMPLE_W = 8,
    parameter int CNT_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clear,
    input  logic                              start,
    input  logic                              in_valid,
    input  logic [N_BITS-1:0]                 in_class,
    input  logic [SAMPLE_W-1:0]               in_sample,
    output logic                              busy,
    output logic                              out_valid,
    output logic [N_BITS-1:0]                 out_index,
    output logic signed [SAMPLE_W+N_BITS:0]   out_coef,
    output logic                              out_single
);
    import wh_pkg::*;

    localparam int NCLS   = 1 << N_BITS;
    localparam int SUM_W  = SAMPLE_W + CNT_W;
    localparam int COEF_W = SAMPLE_W + N_BITS + 1;
    localparam int STG_W  = $clog2(N_BITS);
    localparam int SHIFT  = N_BITS / 2;

    typedef struct packed {
        wh_phase_e                   phase;
        logic [N_BITS-1:0]           cls;
        logic [STG_W-1:0]            stage;
        logic [N_BITS-1:0]           idx;
        logic [NCLS-1:0][COEF_W-1:0] mem;
        logic                        ov;
        logic [N_BITS-1:0]           oidx;
        logic [COEF_W-1:0]           ocoef;
        logic                        osingle;
    } top_t;

    top_t st_d, st_q;

    logic [SUM_W-1:0]  rd_sum;
    logic [CNT_W-1:0]  rd_count;
    logic              div_go;
    logic              div_done;
    logic [SUM_W-1:0]  div_quot;
    logic              busy_int;
    logic              last_cls;
    logic [N_BITS-1:0] idx_m1;
    logic [N_BITS-1:0][NCLS-1:0][COEF_W-1:0] stage_res;

    assign busy_int = (st_q.phase != PH_IDLE) || st_q.ov;

    wh_class_accum #(
        .N_BITS  (N_BITS),
        .SAMPLE_W(SAMPLE_W),
        .CNT_W   (CNT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clear && !busy_int),
        .wr_en    (in_valid && !busy_int),
        .wr_class (in_class),
        .wr_sample(in_sample),
        .rd_class (st_q.cls),
        .rd_sum   (rd_sum),
        .rd_count (rd_count)
    );

    wh_seq_div #(
        .NUM_W(SUM_W),
        .DEN_W(CNT_W)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (rd_sum),
        .den  (rd_count),
        .done (div_done),
        .quot (div_quot)
    );

    for (genvar s = 0; s < N_BITS; s++) begin : g_stage
        wh_bfly_stage #(
            .NCLS  (NCLS),
            .COEF_W(COEF_W),
            .SPAN  (1 << s)
        ) u_stg (
            .vin (st_q.mem),
            .vout(stage_res[s])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.ov  = 1'b0;
        div_go   = 1'b0;
        last_cls = (st_q.cls == N_BITS'(NCLS - 1));
        idx_m1   = st_q.idx - 1'b1;
        case (st_q.phase)
            PH_IDLE: begin
                if (start && !clear && !st_q.ov) begin
                    st_d.phase = PH_DIV_ISSUE;
                    st_d.cls   = '0;
                end
            end
            PH_DIV_ISSUE: begin
                if (rd_count == '0) begin
                    st_d.mem[st_q.cls] = '0;
                    if (last_cls) begin
                        st_d.phase = PH_XFORM;
                        st_d.stage = '0;
                    end else begin
                        st_d.cls = st_q.cls + 1'b1;
                    end
                end else begin
                    div_go     = 1'b1;
                    st_d.phase = PH_DIV_WAIT;
                end
            end
            PH_DIV_WAIT: begin
                if (div_done) begin
                    st_d.mem[st_q.cls] = COEF_W'(div_quot[SAMPLE_W-1:0]);
                    if (last_cls) begin
                        st_d.phase = PH_XFORM;
                        st_d.stage = '0;
                    end else begin
                        st_d.cls   = st_q.cls + 1'b1;
                        st_d.phase = PH_DIV_ISSUE;
                    end
                end
            end
            PH_XFORM: begin
                st_d.mem = stage_res[st_q.stage];
                if (st_q.stage == STG_W'(N_BITS - 1)) begin
                    st_d.phase = PH_EMIT;
                    st_d.idx   = N_BITS'(1);
                end else begin
                    st_d.stage = st_q.stage + 1'b1;
                end
            end
            PH_EMIT: begin
                st_d.ov      = 1'b1;
                st_d.oidx    = st_q.idx;
                st_d.ocoef   = COEF_W'($signed(st_q.mem[st_q.idx]) >>> SHIFT);
                st_d.osingle = ((st_q.idx & idx_m1) == '0);
                if (st_q.idx == {N_BITS{1'b1}}) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy       = busy_int;
    assign out_valid  = st_q.ov;
    assign out_index  = st_q.oidx;
    assign out_coef   = st_q.ocoef;
    assign out_single = st_q.osingle;

endmodule

// File: rtl/wh_leak_spectrum_chk.sv
module wh_leak_spectrum_chk #(
    parameter int N_BITS   = 4,
    parameter int SAMPLE_W = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            busy,
    input logic                            out_valid,
    input logic [N_BITS-1:0]               out_index,
    input logic signed [SAMPLE_W+N_BITS:0] out_coef,
    input logic                            out_single
);
    localparam int NCLS = 1 << N_BITS;
    localparam int LIM  = (NCLS * ((1 << SAMPLE_W) - 1)) / 4;

    p_first_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_index == N_BITS'(1)));

    p_index_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (out_index == $past(out_index) + 1'b1));

    p_no_dc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_index != '0));

    p_burst_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> ($past(out_index) == N_BITS'(NCLS - 1)));

    p_single_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_single == ($countones(out_index) == 1)));

    p_busy_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    p_coef_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((int'(out_coef) <= LIM) && (int'(out_coef) >= -LIM)));

endmodule

bind wh_leak_spectrum wh_leak_spectrum_chk #(
    .N_BITS  (N_BITS),
    .SAMPLE_W(SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .out_valid (out_valid),
    .out_index (out_index),
    .out_coef  (out_coef),
    .out_single(out_single)
);

// File: tb/wh_leak_spectrum_bench.sv
module wh_leak_spectrum_bench;
    localparam int N_BITS   = 4;
    localparam int SAMPLE_W = 8;
    localparam int CNT_W    = 8;
    localparam int NCLS     = 1 << N_BITS;
    localparam int CNT_MAX  = (1 << CNT_W) - 1;
    localparam int LIM      = (NCLS * ((1 << SAMPLE_W) - 1)) / 4;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic                          clear = 1'b0;
    logic                          start = 1'b0;
    logic                          in_valid = 1'b0;
    logic [N_BITS-1:0]             in_class = '0;
    logic [SAMPLE_W-1:0]           in_sample = '0;
    logic                          busy;
    logic                          out_valid;
    logic [N_BITS-1:0]             out_index;
    logic signed [SAMPLE_W+N_BITS:0] out_coef;
    logic                          out_single;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;
    int ref_sum [NCLS];
    int ref_cnt [NCLS];
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    wh_leak_spectrum #(
        .N_BITS  (N_BITS),
        .SAMPLE_W(SAMPLE_W),
        .CNT_W   (CNT_W)
    ) u_wh_leak_spectrum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .start     (start),
        .in_valid  (in_valid),
        .in_class  (in_class),
        .in_sample (in_sample),
        .busy      (busy),
        .out_valid (out_valid),
        .out_index (out_index),
        .out_coef  (out_coef),
        .out_single(out_single)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, got %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic model_clear();
        for (int t = 0; t < NCLS; t++) begin
            ref_sum[t] = 0;
            ref_cnt[t] = 0;
        end
    endtask

    task automatic send(input int cls, input int val);
        @(negedge clk);
        in_valid  = 1'b1;
        in_class  = N_BITS'(cls);
        in_sample = SAMPLE_W'(val);
        if (ref_cnt[cls] < CNT_MAX) begin
            ref_cnt[cls] = ref_cnt[cls] + 1;
            ref_sum[cls] = ref_sum[cls] + val;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        model_clear();
    endtask

    function automatic int expected_coef(input int u);
        int acc = 0;
        for (int t = 0; t < NCLS; t++) begin
            int f;
            f = (ref_cnt[t] == 0) ? 0 : ref_sum[t] / ref_cnt[t];
            if (($countones(u & t) % 2) == 1) acc = acc - f;
            else                               acc = acc + f;
        end
        return acc >>> 2;
    endfunction

    // Runs one analysis and compares the 15 coefficients with the model.
    // poke: drive start and a sample in the middle of the output burst.
    task automatic run_check(input string req, input bit poke);
        int wait_n = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
        while (!out_valid && wait_n < 2000) begin
            @(negedge clk);
            wait_n = wait_n + 1;
        end
        for (int u = 1; u < NCLS; u++) begin
            int act;
            int exp;
            act = int'(out_coef);
            exp = expected_coef(u);
            chk(out_valid == 1'b1, "R5", "out_valid in burst", int'(out_valid), 1);
            chk(int'(out_index) == u, "R5", "index order", int'(out_index), u);
            chk(act == exp, req, $sformatf("coef u=%0d", u), act, exp);
            chk(out_single == ($countones(u) == 1), "R6", $sformatf("single tag u=%0d", u),
                int'(out_single), int'($countones(u) == 1));
            chk(act <= LIM && act >= -LIM, "R10", "coef bound", act, LIM);
            if (poke && u == 5) begin
                start     = 1'b1;
                clear     = 1'b1;
                in_valid  = 1'b1;
                in_class  = N_BITS'(0);
                in_sample = SAMPLE_W'(255);
            end
            @(negedge clk);
            start    = 1'b0;
            clear    = 1'b0;
            in_valid = 1'b0;
        end
        chk(out_valid == 1'b0, "R5", "out_valid after burst", int'(out_valid), 0);
        chk(busy == 1'b0, "R7", "busy after burst", int'(busy), 0);
        if (poke) begin
            int seen = 0;
            for (int k = 0; k < 400; k++) begin
                @(negedge clk);
                if (out_valid || busy) seen = seen + 1;
            end
            chk(seen == 0, "R7", "start during burst ignored", seen, 0);
        end
    endtask

    task automatic test_reset();
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && busy == 1'b0, "R1", "idle after reset",
            int'(out_valid | busy), 0);
        model_clear();
        // R1: all classes empty, spectrum must be all zero
        run_check("R1", 1'b0);
    endtask

    task automatic test_single_class();
        // R4: one class at 100 gives +-25 by parity of u AND 5
        do_clear();
        for (int k = 0; k < 4; k++) send(5, 100);
        run_check("R4", 1'b0);
    endtask

    task automatic test_floor();
        // R4: mean 1 in class 1 gives 0 or -1 (floor, not truncation)
        do_clear();
        send(1, 1);
        run_check("R4", 1'b0);
    endtask

    task automatic test_sparse();
        // R3: only three classes populated, uneven means; rest must count as zero
        do_clear();
        send(2, 10); send(2, 11); send(2, 13);
        send(7, 200); send(7, 1); send(7, 0);
        send(12, 255); send(12, 254);
        run_check("R3", 1'b0);
    endtask

    task automatic test_random();
        // R2: pseudo-random fill of every class, 1..6 samples each
        do_clear();
        for (int t = 0; t < NCLS; t++) begin
            int n;
            lfsr = lfsr_next(lfsr);
            n = 1 + int'(lfsr[2:0]) % 6;
            for (int k = 0; k < n; k++) begin
                lfsr = lfsr_next(lfsr);
                send(t, int'(lfsr[7:0]));
            end
        end
        run_check("R2", 1'b0);
    endtask

    task automatic test_busy_ignore();
        // R7 and R8: inputs during the burst are dropped; a rerun reproduces the spectrum
        run_check("R7", 1'b1);
        run_check("R8", 1'b0);
    endtask

    task automatic test_clear();
        // R8: clear empties everything, spectrum all zero
        do_clear();
        run_check("R8", 1'b0);
    endtask

    task automatic test_saturate();
        // R9: 255 samples of 10 fill class 3; later 200s are dropped, mean stays 10
        do_clear();
        for (int k = 0; k < CNT_MAX; k++) send(3, 10);
        send(3, 200); send(3, 200); send(3, 200);
        send(9, 40);
        run_check("R9", 1'b0);
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        test_reset();
        test_single_class();
        test_floor();
        test_sparse();
        test_random();
        test_busy_ignore();
        test_clear();
        test_saturate();
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule